// File: doc/BRIEF.md
# Burst ROM Line Read Sequencer

This block fetches one line from a burst-mode ROM on an asynchronous-style external bus. An internal master starts it with a single request that carries a byte address and a chip-select index. The block then works through a fixed state order: a start state, a group of first-access wait states, and a data state for the first word. Each later word gets its own wait group followed by a data state, and the final data state ends the burst. One line is four 32-bit words, or 16 bytes. The first word and the later words each have their own programmable wait count. An active-low wait input from the memory can stretch any wait group.

The chip select and read strobe are held low for the whole burst. The bus-start strobe marks only the first state. The word address steps through the 16-byte aligned line starting at the requested word and wraps inside that line. Each word is captured at the end of its data state into a slot chosen by its address. A one-cycle done pulse follows the last data state, and the assembled line is then available on the response port.

Top module: `brom_burst_seq`

## Requirements
- R1: While reset is low, and in the idle state after it, every bus_cs_n line is 1, bus_rd_n is 1, bus_bs_n is 1 and rsp_done is 0. Reset also clears rsp_data to zero.
- R2: A request is taken only when req_valid is 1 in the idle state. A req_valid pulse during a burst does not change that burst's timing, addresses or data, and no new burst starts after it.
- R3: From the start state through the final data state, bus_rd_n is 0 and only bus_cs_n[req_cs] is 0 (active low, bit index equal to the request's index). Both return high in the cycle after the final data state.
- R4: bus_bs_n is 0 for exactly one cycle per burst, namely the start state, which is the cycle after the accepting edge.
- R5: Between the start state and the first data state there are exactly cfg_first_wait wait cycles. The count is taken at acceptance, and zero means none.
- R6: Before each of the second, third and fourth data states there are exactly cfg_next_wait wait cycles. The count is taken at acceptance.
- R7: If the request is sampled at edge 0 and no extension occurs, rsp_done is 1 for exactly one cycle, beginning at edge cfg_first_wait + 3*cfg_next_wait + 5. In that cycle bus_rd_n is 1.
- R8: Let s be request address bits [3:2]. Beat k drives bus_addr = {req_addr[25:4], (s+k) mod 4, 2'b00}.
- R9: Word j of rsp_data (bits 32j+31 down to 32j) holds the bus_data value present at the end of the data state whose address bits [3:2] equal j. It stays unchanged until the next capture.
- R10: bus_wait_n (active low) is sampled only on the last programmed cycle of a wait group. Each such cycle with it low adds one wait cycle, and the added cycle samples again. When a wait count is zero, that group samples nothing and bus_wait_n has no effect.
- R11: A request presented in the done cycle is accepted, and its start state (bus_bs_n = 0) appears in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst read request |
| req_addr | input | 26 | Byte address of the first word wanted |
| req_cs | input | 3 | Chip-select index for the burst |
| cfg_first_wait | input | 4 | Wait cycles before the first data state |
| cfg_next_wait | input | 4 | Wait cycles before each later data state |
| rsp_done | output | 1 | One-cycle line-complete pulse |
| rsp_data | output | 128 | Assembled line, word j at bits 32j+31:32j |
| bus_cs_n | output | 8 | Active-low chip selects |
| bus_addr | output | 26 | External byte address |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_bs_n | output | 1 | Active-low bus-start strobe |
| bus_data | input | 32 | External read data |
| bus_wait_n | input | 1 | Active-low wait request from the memory |

## Verification
The done pulse of one burst and the acceptance of the next request can fall in the same cycle. The bench provokes this by holding req_valid high through a whole burst, which the busy sequencer must ignore, and then changing the request address in the done cycle. It judges the result in three ways: the first line must be complete when done is seen, bus_bs_n must be low in the very next cycle, and the second line must hold the data of the new address. A second coincidence is a wait extension that lands on the last programmed wait cycle of a later word. Stall windows placed at fixed cycle offsets from acceptance provoke it, and it is judged by the exact done cycle.

// File: rtl/brom_pkg.sv
package brom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_WFST  = 3'd2,
    ST_DMID  = 3'd3,
    ST_WNXT  = 3'd4,
    ST_DLAST = 3'd5
  } brom_state_e;

  function automatic logic is_wait_state(brom_state_e s);
    return (s == ST_WFST) || (s == ST_WNXT);
  endfunction

  function automatic logic is_data_state(brom_state_e s);
    return (s == ST_DMID) || (s == ST_DLAST);
  endfunction

endpackage

// File: rtl/brom_wait_ctr.sv
module brom_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              active,
  input  logic              wait_req,
  output logic              on_last,
  output logic              extend,
  output logic              expired
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [WAIT_W-1:0] cnt_q;

  // the memory's wait input only matters on the last programmed cycle
  assign on_last = active && (cnt_q == ONE);
  assign extend  = on_last && wait_req;
  assign expired = on_last && !wait_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (active && !on_last)
      cnt_q <= cnt_q - ONE;
  end

endmodule

// File: rtl/brom_beat_addr.sv
module brom_beat_addr #(
  parameter int ADDR_W = 26,
  parameter int BEATS  = 4,
  parameter int LSB_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          start_addr,
  input  logic                       advance,
  output logic [ADDR_W-1:0]          addr,
  output logic [$clog2(BEATS)-1:0]   slot,
  output logic                       last_beat,
  output logic                       next_last
);
  localparam int OFF_W  = $clog2(BEATS);
  localparam int LINE_W = OFF_W + LSB_W;
  localparam int UP_W   = ADDR_W - LINE_W;

  logic [UP_W-1:0]  upper_q;
  logic [OFF_W-1:0] first_q;
  logic [OFF_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      first_q <= '0;
      beat_q  <= '0;
    end else if (start) begin
      upper_q <= start_addr[ADDR_W-1:LINE_W];
      first_q <= start_addr[LINE_W-1:LSB_W];
      beat_q  <= '0;
    end else if (advance) begin
      beat_q  <= beat_q + OFF_W'(1);
    end
  end

  // modular add of OFF_W bits wraps inside the aligned line
  assign slot      = first_q + beat_q;
  assign addr      = {upper_q, slot, {LSB_W{1'b0}}};
  assign last_beat = (beat_q == OFF_W'(BEATS - 1));
  assign next_last = (beat_q == OFF_W'(BEATS - 2));

endmodule

// File: rtl/brom_line_buf.sv
module brom_line_buf #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic [$clog2(BEATS)-1:0]   slot,
  input  logic [DATA_W-1:0]          data,
  output logic [BEATS*DATA_W-1:0]    line
);
  localparam int OFF_W = $clog2(BEATS);

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (capture && (slot == OFF_W'(g)))
        word_q <= data;
    end
    assign line[g*DATA_W +: DATA_W] = word_q;
  end

endmodule

// File: rtl/brom_burst_seq.sv
module brom_burst_seq
  import brom_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  parameter int NUM_CS = 8,
  parameter int WAIT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [$clog2(NUM_CS)-1:0] req_cs,
  input  logic [WAIT_W-1:0]         cfg_first_wait,
  input  logic [WAIT_W-1:0]         cfg_next_wait,
  output logic                      rsp_done,
  output logic [BEATS*DATA_W-1:0]   rsp_data,
  output logic [NUM_CS-1:0]         bus_cs_n,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic                      bus_rd_n,
  output logic                      bus_bs_n,
  input  logic [DATA_W-1:0]         bus_data,
  input  logic                      bus_wait_n
);
  localparam int CS_IDX_W = $clog2(NUM_CS);
  localparam int OFF_W    = $clog2(BEATS);
  localparam int LSB_W    = $clog2(DATA_W / 8);

  brom_state_e state_q, state_d;
  logic [CS_IDX_W-1:0] cs_q;
  logic [WAIT_W-1:0]   fw_q, nw_q;
  logic                done_q;

  // named internal events, also observed by the checker
  logic accept, busy, capture_evt, advance_evt, wait_extend, wait_expired, wait_last;
  logic load_first, load_next;
  logic [WAIT_W-1:0] load_val;
  logic [OFF_W-1:0]  slot;
  logic last_beat, next_last;

  assign busy        = (state_q != ST_IDLE);
  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign capture_evt = is_data_state(state_q);
  assign advance_evt = (state_q == ST_DMID);
  assign load_first  = (state_q == ST_START) && (fw_q != '0);
  assign load_next   = (state_q == ST_DMID) && (nw_q != '0);
  assign load_val    = load_first ? fw_q : nw_q;

  brom_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_first || load_next),
    .load_val (load_val),
    .active   (is_wait_state(state_q)),
    .wait_req (!bus_wait_n),
    .on_last  (wait_last),
    .extend   (wait_extend),
    .expired  (wait_expired)
  );

  brom_beat_addr #(.ADDR_W(ADDR_W), .BEATS(BEATS), .LSB_W(LSB_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (req_addr),
    .advance    (advance_evt),
    .addr       (bus_addr),
    .slot       (slot),
    .last_beat  (last_beat),
    .next_last  (next_last)
  );

  brom_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture_evt),
    .slot    (slot),
    .data    (bus_data),
    .line    (rsp_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_START;
      ST_START: if (fw_q != '0)   state_d = ST_WFST;
                else if (last_beat) state_d = ST_DLAST;
                else              state_d = ST_DMID;
      ST_WFST:  if (wait_expired) state_d = last_beat ? ST_DLAST : ST_DMID;
      ST_DMID:  if (nw_q != '0)   state_d = ST_WNXT;
                else              state_d = next_last ? ST_DLAST : ST_DMID;
      ST_WNXT:  if (wait_expired) state_d = last_beat ? ST_DLAST : ST_DMID;
      ST_DLAST: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= '0;
      fw_q    <= '0;
      nw_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_DLAST);
      if (accept) begin
        cs_q <= req_cs;
        fw_q <= cfg_first_wait;
        nw_q <= cfg_next_wait;
      end
    end
  end

  assign rsp_done = done_q;
  assign bus_cs_n = busy ? ~(NUM_CS'(1) << cs_q) : '1;
  assign bus_rd_n = !busy;
  assign bus_bs_n = (state_q != ST_START);

endmodule

// File: rtl/brom_burst_seq_chk.sv
module brom_burst_seq_chk #(
  parameter int ADDR_W = 26,
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_bs_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rsp_done,
  input logic              capture,
  input logic              extend,
  input logic              accept
);

  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  p_rd_with_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (bus_cs_n != '1));

  p_cs_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && $past(!bus_rd_n)) |-> $stable(bus_cs_n));

  p_bs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_bs_n |=> bus_bs_n);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> bus_rd_n);

  p_addr_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && $past(!bus_rd_n) && !$stable(bus_addr)) |-> $past(capture));

  p_extend_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    extend |=> (!capture && $stable(bus_addr)));

  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> bus_rd_n);

endmodule

bind brom_burst_seq brom_burst_seq_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_cs_n (bus_cs_n),
  .bus_rd_n (bus_rd_n),
  .bus_bs_n (bus_bs_n),
  .bus_addr (bus_addr),
  .rsp_done (rsp_done),
  .capture  (capture_evt),
  .extend   (wait_extend),
  .accept   (accept)
);

// File: tb/brom_burst_seq_tb_top.sv
module brom_burst_seq_tb_top;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int BEATS  = 4;
  localparam int NUM_CS = 8;
  localparam int WAIT_W = 4;
  localparam int NVEC   = 6;

  // {addr, cs, first wait, next wait, stall from, stall to, expected extra}
  localparam logic [60:0] VECS [NVEC] = '{
    {26'h0000100, 3'd0, 4'd2,  4'd1,  8'd0, 8'd0, 8'd0},
    {26'h00ABC0C, 3'd5, 4'd0,  4'd0,  8'd0, 8'd3, 8'd0},
    {26'h1234568, 3'd2, 4'd1,  4'd1,  8'd3, 8'd5, 8'd2},
    {26'h0000FF4, 3'd7, 4'd3,  4'd2,  8'd0, 8'd6, 8'd3},
    {26'h2000004, 3'd1, 4'd1,  4'd0,  8'd1, 8'd2, 8'd1},
    {26'h3FFFFFC, 3'd4, 4'd15, 4'd15, 8'd0, 8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                    req_valid = 1'b0;
  logic [ADDR_W-1:0]       req_addr = '0;
  logic [2:0]              req_cs = '0;
  logic [WAIT_W-1:0]       cfg_first_wait = '0;
  logic [WAIT_W-1:0]       cfg_next_wait = '0;
  logic                    rsp_done;
  logic [BEATS*DATA_W-1:0] rsp_data;
  logic [NUM_CS-1:0]       bus_cs_n;
  logic [ADDR_W-1:0]       bus_addr;
  logic                    bus_rd_n, bus_bs_n, bus_wait_n;
  logic [DATA_W-1:0]       bus_data;

  logic [31:0] cyc = '0;
  logic [31:0] t0 = '0;
  logic        stall_en = 1'b0;
  logic [7:0]  stall_lo = '0, stall_hi = '0;
  int n_chk = 0, n_bad = 0;

  always_ff @(posedge clk) cyc <= cyc + 32'd1;

  function automatic logic [DATA_W-1:0] rom_word(logic [ADDR_W-1:0] a);
    return {a[15:0] ^ 16'h5A3C, a[25:10]};
  endfunction

  assign bus_data   = rom_word(bus_addr);
  assign bus_wait_n = !(stall_en && ((cyc - t0) >= 32'(stall_lo)) && ((cyc - t0) < 32'(stall_hi)));

  brom_burst_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS),
                   .NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cs(req_cs), .cfg_first_wait(cfg_first_wait), .cfg_next_wait(cfg_next_wait),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .bus_cs_n(bus_cs_n),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_bs_n(bus_bs_n),
    .bus_data(bus_data), .bus_wait_n(bus_wait_n)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_line(input logic [ADDR_W-1:0] a, input string tag);
    for (int j = 0; j < BEATS; j++) begin
      logic [DATA_W-1:0] e;
      e = rom_word({a[25:4], 2'(j), 2'b00});
      check(rsp_data[j*DATA_W +: DATA_W] == e, tag, 64'(rsp_data[j*DATA_W +: DATA_W]), 64'(e));
    end
  endtask

  task automatic run_burst(input logic [ADDR_W-1:0] a, input logic [2:0] cs,
                           input logic [3:0] f, input logic [3:0] n,
                           input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] ex, input bit poke);
    int idx, act, bs_cnt, nchg, exp_done;
    bit bs_first, cs_ok;
    logic [ADDR_W-1:0] seq [4];
    logic [ADDR_W-1:0] last;
    @(negedge clk);
    req_addr = a; req_cs = cs; cfg_first_wait = f; cfg_next_wait = n;
    stall_lo = lo; stall_hi = hi; stall_en = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; t0 = cyc; stall_en = 1'b1;
    idx = 0; act = 0; bs_cnt = 0; nchg = 0; bs_first = 0; cs_ok = 1;
    for (int k = 0; k < 4; k++) seq[k] = '0;
    seq[0] = bus_addr; last = bus_addr;
    while (!rsp_done && idx < 400) begin
      if (!bus_rd_n) begin
        act++;
        if (bus_cs_n != ~(NUM_CS'(1) << cs)) cs_ok = 0;
      end
      if (!bus_bs_n) begin
        bs_cnt++;
        if (idx == 0) bs_first = 1;
      end
      if (idx > 0 && !bus_rd_n && bus_addr != last) begin
        nchg++;
        if (nchg < 4) seq[nchg] = bus_addr;
        last = bus_addr;
      end
      if (poke && idx == 3) begin req_valid = 1'b1; req_addr = a ^ 26'h1555550; end
      if (poke && idx == 4) req_valid = 1'b0;
      @(negedge clk);
      idx++;
    end
    exp_done = 1 + int'(f) + (BEATS - 1) * int'(n) + BEATS + int'(ex);
    check(idx == exp_done, "R5 R6 R10 R7 done cycle", 64'(idx), 64'(exp_done));
    check(act == exp_done, "R3 read strobe span", 64'(act), 64'(exp_done));
    check(cs_ok, "R3 chip select line", 64'(cs_ok), 64'd1);
    check(bs_cnt == 1 && bs_first, "R4 bus start once", 64'(bs_cnt), 64'd1);
    check(nchg == BEATS - 1, "R8 address steps", 64'(nchg), 64'(BEATS - 1));
    for (int k = 0; k < BEATS; k++) begin
      logic [ADDR_W-1:0] ea;
      ea = {a[25:4], 2'(a[3:2] + 2'(k)), 2'b00};
      check(seq[k] == ea, "R8 wrap address", 64'(seq[k]), 64'(ea));
    end
    check_line(a, "R9 line data");
    stall_en = 1'b0;
    @(negedge clk);
    check(!rsp_done, "R7 done one cycle", 64'(rsp_done), 64'd0);
    if (poke) check(bus_rd_n, "R2 busy request ignored", 64'(bus_rd_n), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_cs_n == '1, "R1 reset cs", 64'(bus_cs_n), 64'hFF);
    check(bus_rd_n && bus_bs_n, "R1 reset strobes", 64'({bus_rd_n, bus_bs_n}), 64'h3);
    check(!rsp_done, "R1 reset done", 64'(rsp_done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_cs_n == '1 && bus_rd_n, "R1 idle after reset", 64'(bus_cs_n), 64'hFF);

    for (int v = 0; v < NVEC; v++) begin
      logic [60:0] e;
      e = VECS[v];
      run_burst(e[60:35], e[34:32], e[31:28], e[27:24], e[23:16], e[15:8], e[7:0], 1'b0);
    end

    // R2: request pulse during a burst must be ignored
    run_burst(26'h0040008, 3'd3, 4'd1, 4'd1, 8'd0, 8'd0, 8'd0, 1'b1);

    // R11: back-to-back, second request accepted in the done cycle
    begin
      int guard;
      @(negedge clk);
      req_addr = 26'h0100004; req_cs = 3'd6; cfg_first_wait = 4'd1; cfg_next_wait = 4'd0;
      req_valid = 1'b1;
      guard = 0;
      @(negedge clk);
      while (!rsp_done && guard < 200) begin @(negedge clk); guard++; end
      check_line(26'h0100004, "R2 R9 first line with held request");
      req_addr = 26'h020003C;
      @(negedge clk);
      req_valid = 1'b0;
      check(!bus_bs_n, "R11 start right after done", 64'(bus_bs_n), 64'd0);
      guard = 0;
      while (!rsp_done && guard < 200) begin @(negedge clk); guard++; end
      check_line(26'h020003C, "R11 second line");
    end

    // R1: reset in the middle of a burst
    @(negedge clk);
    req_addr = 26'h0000020; cfg_first_wait = 4'd5; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(bus_cs_n == '1, "R1 mid-burst reset cs", 64'(bus_cs_n), 64'hFF);
    check(bus_rd_n && bus_bs_n && !rsp_done, "R1 mid-burst reset strobes",
          64'({bus_rd_n, bus_bs_n, rsp_done}), 64'h6);
    check(rsp_data == '0, "R1 line cleared", 64'(rsp_data[63:0]), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rd_n, "R1 idle after release", 64'(bus_rd_n), 64'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule